// File: doc/BRIEF.md
# Microcoded ROM/RAM Memory Bus Unit

This unit sits between a shared 16-bit address bus and a shared 8-bit data bus and holds two on-chip stores: a read-only program store and a read/write working store. Each store holds 2^ARR_AW bytes. At ARR_AW = 15 each store is 32 KB. The default is ARR_AW = 10 so that elaboration stays light. A control word from the sequencer carries a 3-bit bank code that selects one action: put the program store on the bus, put the working store on the bus, or load the bus into the working store.

Working-store writes are not level triggered. A separate request bit in the control word starts a self-timed one-shot that drives an active-low write strobe for a fixed number of clock cycles. The address and data are captured when the strobe is fired. The store is updated on the strobe's rising edge, and only if the load code was present in the same cycle as the request.

Both stores keep their bits in reverse order relative to the bus: array bit 7 is bus bit 0. The unit swaps the order on every read and every write. When neither read code is active, the bus output is released. This is modelled as an output-enable flag with the data forced to zero.

Top module: `membus_unit`

## Requirements
- R1: During and straight after reset, `wr_strobe_n` is 1, `bus_oe` is 0 and `bus_out` is 0.
- R2: Bank code 001 sets `bus_oe` to 1 and drives `bus_out` from the program store in the same cycle.
- R3: Bank code 010 sets `bus_oe` to 1 and drives `bus_out` with the byte that was last committed at the addressed working-store location.
- R4: With any bank code other than 001 or 010, including the load code 011, `bus_oe` is 0 and `bus_out` is 0.
- R5: The bank code is taken from `ctrl_word[10:8]` and the write request from `ctrl_word[12]`. No other control bit has any effect.
- R6: When a write request is sampled at a clock edge while no strobe is active, `wr_strobe_n` goes low after that edge. It stays low for exactly STROBE_CYC cycles (default 6) and then returns high.
- R7: A write request that arrives while the strobe is low is ignored. It neither lengthens the strobe nor writes its address or data.
- R8: A working-store write happens only when the load code 011 and the write request occur in the same cycle. Load code without a request writes nothing. A request with any other code fires the strobe but writes nothing.
- R9: The address and data are captured at the edge that fires the strobe. The store changes at the edge where the strobe returns high, so a read while the strobe is low returns the old byte.
- R10: Only `addr[ARR_AW-1:0]` indexes either store. Higher address bits are ignored, so addresses that differ only there alias.
- R11: Array bit 7 is bus bit 0 (full bit reversal). Program-store entry i holds ((i mod 256) XOR 0xA5) in array bit order, so the bus reads the bit-reverse of that value.
- R12: The program store and the working store never drive the bus in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Shared address bus |
| ctrl_word | input | 16 | Control word: bank code in bits 10:8, write request in bit 12 |
| bus_in | input | 8 | Data bus value seen by the unit (write source) |
| bus_out | output | 8 | Data the unit drives onto the bus |
| bus_oe | output | 1 | High while the unit drives the bus |
| wr_strobe_n | output | 1 | Active-low one-shot write strobe |

## Verification
If the strobe counter is corrupted, the strobe shows up at the pins with the wrong length, and the error is visible on the first cycle in which `wr_strobe_n` stays low too long or rises too early. Corrupted captured write state does not show up until the working store is read back. That read is the first chance to see a stray write from a load code held without a request, or a write at the wrong index. The tests therefore read the store in the middle of the strobe window and again just after it. A decode fault is visible in the same cycle as the bad code, because the read paths are combinational: wrong `bus_oe` or a bit-reversed byte.

// File: rtl/membus_pkg.sv
package membus_pkg;

   typedef enum logic [2:0] {
      BANK_IDLE  = 3'b000,
      BANK_ROMRD = 3'b001,
      BANK_RAMRD = 3'b010,
      BANK_RAMWR = 3'b011
   } bank_e;

   typedef struct packed {
      logic rom_drv;
      logic ram_drv;
      logic load;
   } bank_sel_t;

endpackage

// File: rtl/membus_decode.sv
module membus_decode
   import membus_pkg::*;
#(
   parameter int CTRL_W    = 16,
   parameter int BANK_LSB  = 8,
   parameter int PULSE_BIT = 12
) (
   input  logic [CTRL_W-1:0] ctrl_word,
   output bank_sel_t         sel,
   output logic              pulse_req
);

   localparam int BANK_MSB = BANK_LSB + 2;

   generate
      if (BANK_MSB >= CTRL_W) begin : g_bad_bank
         $error("bank field exceeds control word");
      end
      if (PULSE_BIT >= CTRL_W) begin : g_bad_pulse
         $error("pulse bit exceeds control word");
      end
      if (PULSE_BIT >= BANK_LSB && PULSE_BIT <= BANK_MSB) begin : g_overlap
         $error("pulse bit overlaps bank field");
      end
   endgenerate

   bank_e code;

   always_comb begin
      code          = bank_e'(ctrl_word[BANK_MSB:BANK_LSB]);
      sel.rom_drv   = (code == BANK_ROMRD);
      sel.ram_drv   = (code == BANK_RAMRD);
      sel.load      = (code == BANK_RAMWR);
      pulse_req     = ctrl_word[PULSE_BIT];
   end

endmodule

// File: rtl/membus_swizzle.sv
module membus_swizzle #(
   parameter int W       = 8,
   parameter bit REVERSE = 1'b1
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (REVERSE) begin : g_rev
         for (genvar b = 0; b < W; b++) begin : g_bit
            assign dout[b] = din[W-1-b];
         end
      end else begin : g_pass
         assign dout = din;
      end
   endgenerate

endmodule

// File: rtl/membus_strobe.sv
module membus_strobe #(
   parameter int STROBE_CYC = 6,
   parameter int AW         = 10,
   parameter int DW         = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic          load,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   output logic          strobe_n,
   output logic          commit,
   output logic [AW-1:0] commit_addr,
   output logic [DW-1:0] commit_data
);

   localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

   generate
      if (STROBE_CYC < 1) begin : g_bad_width
         $error("strobe width must be at least one cycle");
      end
   endgenerate

   logic             active;
   logic             pend;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active      <= 1'b0;
         pend        <= 1'b0;
         cnt         <= '0;
         commit_addr <= '0;
         commit_data <= '0;
      end else if (!active) begin
         if (fire) begin
            active      <= 1'b1;
            pend        <= load;
            cnt         <= CNT_LOAD;
            commit_addr <= addr_in;
            commit_data <= data_in;
         end
      end else if (cnt == '0) begin
         active <= 1'b0;
         pend   <= 1'b0;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign strobe_n = ~active;
   assign commit   = active & pend & (cnt == '0);

endmodule

// File: rtl/membus_rom.sv
module membus_rom #(
   parameter int            AW      = 10,
   parameter int            DW      = 8,
   parameter logic [DW-1:0] ROM_XOR = 8'hA5
) (
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = DW'(i) ^ ROM_XOR;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/membus_ram.sv
module membus_ram #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/membus_unit.sv
module membus_unit
   import membus_pkg::*;
#(
   parameter int            ADDR_W     = 16,
   parameter int            DATA_W     = 8,
   parameter int            CTRL_W     = 16,
   parameter int            ARR_AW     = 10,
   parameter int            BANK_LSB   = 8,
   parameter int            PULSE_BIT  = 12,
   parameter int            STROBE_CYC = 6,
   parameter bit            REVERSE    = 1'b1,
   parameter logic [DATA_W-1:0] ROM_XOR = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              wr_strobe_n
);

   generate
      if (ARR_AW > ADDR_W) begin : g_bad_aw
         $error("array index wider than address bus");
      end
      if (ARR_AW > 15) begin : g_too_deep
         $error("array depth above 32K entries");
      end
   endgenerate

   bank_sel_t           sel;
   logic                pulse_req;
   logic                rom_drv;
   logic                ram_drv;
   logic                ram_we;
   logic [ARR_AW-1:0]   idx;
   logic [ARR_AW-1:0]   w_idx;
   logic [DATA_W-1:0]   w_arr;
   logic [DATA_W-1:0]   w_bus_arr;
   logic [DATA_W-1:0]   rom_arr;
   logic [DATA_W-1:0]   ram_arr;
   logic [DATA_W-1:0]   rom_bus;
   logic [DATA_W-1:0]   ram_bus;

   assign idx = addr[ARR_AW-1:0];

   membus_decode #(
      .CTRL_W   (CTRL_W),
      .BANK_LSB (BANK_LSB),
      .PULSE_BIT(PULSE_BIT)
   ) u_dec (
      .ctrl_word(ctrl_word),
      .sel      (sel),
      .pulse_req(pulse_req)
   );

   assign rom_drv = sel.rom_drv;
   assign ram_drv = sel.ram_drv;

   membus_swizzle #(.W(DATA_W), .REVERSE(REVERSE)) u_sw_wr (
      .din (bus_in),
      .dout(w_bus_arr)
   );

   membus_strobe #(
      .STROBE_CYC(STROBE_CYC),
      .AW        (ARR_AW),
      .DW        (DATA_W)
   ) u_strb (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (pulse_req),
      .load       (sel.load),
      .addr_in    (idx),
      .data_in    (w_bus_arr),
      .strobe_n   (wr_strobe_n),
      .commit     (ram_we),
      .commit_addr(w_idx),
      .commit_data(w_arr)
   );

   membus_rom #(.AW(ARR_AW), .DW(DATA_W), .ROM_XOR(ROM_XOR)) u_rom (
      .raddr(idx),
      .rdata(rom_arr)
   );

   membus_ram #(.AW(ARR_AW), .DW(DATA_W)) u_ram (
      .clk  (clk),
      .we   (ram_we),
      .waddr(w_idx),
      .wdata(w_arr),
      .raddr(idx),
      .rdata(ram_arr)
   );

   membus_swizzle #(.W(DATA_W), .REVERSE(REVERSE)) u_sw_rom (
      .din (rom_arr),
      .dout(rom_bus)
   );

   membus_swizzle #(.W(DATA_W), .REVERSE(REVERSE)) u_sw_ram (
      .din (ram_arr),
      .dout(ram_bus)
   );

   always_comb begin
      bus_oe  = rom_drv | ram_drv;
      bus_out = '0;
      if (rom_drv) begin
         bus_out = rom_bus;
      end else if (ram_drv) begin
         bus_out = ram_bus;
      end
   end

endmodule

// File: rtl/membus_unit_chk.sv
module membus_unit_chk #(
   parameter int DATA_W     = 8,
   parameter int CTRL_W     = 16,
   parameter int PULSE_BIT  = 12,
   parameter int STROBE_CYC = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic [DATA_W-1:0] bus_out,
   input logic              bus_oe,
   input logic              wr_strobe_n,
   input logic              rom_drv,
   input logic              ram_drv,
   input logic              ram_we
);

   localparam int LW = $clog2(STROBE_CYC + 2) + 1;

   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (wr_strobe_n) begin
         low_cnt <= '0;
      end else begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   assert_one_driver_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_drv, ram_drv}));

   assert_released_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_out == '0));

   assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_strobe_n) |-> (low_cnt == LW'(STROBE_CYC)));

   assert_strobe_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_strobe_n) |-> $past(ctrl_word[PULSE_BIT]));

   assert_commit_at_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> $rose(wr_strobe_n));

   assert_commit_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !wr_strobe_n);

endmodule

bind membus_unit membus_unit_chk #(
   .DATA_W    (DATA_W),
   .CTRL_W    (CTRL_W),
   .PULSE_BIT (PULSE_BIT),
   .STROBE_CYC(STROBE_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctrl_word  (ctrl_word),
   .bus_out    (bus_out),
   .bus_oe     (bus_oe),
   .wr_strobe_n(wr_strobe_n),
   .rom_drv    (rom_drv),
   .ram_drv    (ram_drv),
   .ram_we     (ram_we)
);

// File: tb/membus_unit_test.sv
module membus_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int S          = 6;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] addr;
   logic [15:0] ctrl_word;
   logic [7:0]  bus_in;
   logic [7:0]  bus_out;
   logic        bus_oe;
   logic        wr_strobe_n;

   int n_chk = 0;
   int n_err = 0;

   membus_unit uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (addr),
      .ctrl_word  (ctrl_word),
      .bus_in     (bus_in),
      .bus_out    (bus_out),
      .bus_oe     (bus_oe),
      .wr_strobe_n(wr_strobe_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] cw(input logic [2:0] code, input logic req);
      return (16'(code) << 8) | (16'(req) << 12);
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int b = 0; b < 8; b++) r[b] = v[7-b];
      return r;
   endfunction

   function automatic logic [7:0] rom_exp(input logic [15:0] a);
      return rev8(a[7:0] ^ 8'hA5);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rom_read(input logic [15:0] a);
      @(negedge clk);
      addr = a; ctrl_word = cw(3'b001, 1'b0); #1;
      chk("R2 rom oe", 32'(bus_oe), 32'd1);
      chk("R11 rom byte", 32'(bus_out), 32'(rom_exp(a)));
   endtask

   task automatic ram_read(input logic [15:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      addr = a; ctrl_word = cw(3'b010, 1'b0); #1;
      chk(req, 32'(bus_oe), 32'd1);
      chk(req, 32'(bus_out), 32'(exp));
   endtask

   // fire with given code, hold until strobe returns high, check width (R6)
   task automatic fire(input logic [15:0] a, input logic [7:0] d, input logic [2:0] code);
      int n;
      @(negedge clk);
      addr = a; bus_in = d; ctrl_word = cw(code, 1'b1);
      @(negedge clk);
      ctrl_word = 16'h0000; #1;
      n = 0;
      while (!wr_strobe_n && n < 4*S) begin
         n++;
         @(negedge clk); #1;
      end
      chk("R6 strobe width", 32'(n), 32'(S));
   endtask

   task automatic t_reset;
      rst_n = 1'b0; addr = '0; ctrl_word = '0; bus_in = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 strobe", 32'(wr_strobe_n), 32'd1);
      chk("R1 oe", 32'(bus_oe), 32'd0);
      chk("R1 out", 32'(bus_out), 32'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 strobe after", 32'(wr_strobe_n), 32'd1);
   endtask

   task automatic t_rom;
      rom_read(16'h0000);
      rom_read(16'h0001);
      rom_read(16'h0055);
      rom_read(16'h03FF);
   endtask

   task automatic t_idle_codes;
      for (int c = 0; c < 8; c++) begin
         if (c == 1 || c == 2) continue;
         @(negedge clk);
         addr = 16'h0001; ctrl_word = cw(3'(c), 1'b0) | 16'h68FF; #1;
         chk("R4 oe", 32'(bus_oe), 32'd0);
         chk("R4 out", 32'(bus_out), 32'd0);
      end
      // R5: stray bits outside the fields do not change a ROM read
      @(negedge clk);
      addr = 16'h0002; ctrl_word = cw(3'b001, 1'b0) | 16'hE8FF; #1;
      chk("R5 stray bits", 32'(bus_out), 32'(rom_exp(16'h0002)));
      chk("R5 no strobe", 32'(wr_strobe_n), 32'd1);
   endtask

   task automatic t_write_read;
      fire(16'h0010, 8'h01, 3'b011);
      fire(16'h0011, 8'h80, 3'b011);
      fire(16'h03FF, 8'hC3, 3'b011);
      ram_read(16'h0010, 8'h01, "R3 read 0x01");
      ram_read(16'h0011, 8'h80, "R3 read 0x80");
      ram_read(16'h03FF, 8'hC3, "R3 read 0xC3");
      fire(16'h0010, 8'h3C, 3'b011);
      ram_read(16'h0010, 8'h3C, "R3 overwrite");
   endtask

   task automatic t_no_pulse_no_load;
      fire(16'h0020, 8'h11, 3'b011);
      @(negedge clk);
      addr = 16'h0020; bus_in = 8'h99; ctrl_word = cw(3'b011, 1'b0);
      for (int k = 0; k < S + 3; k++) begin
         @(negedge clk); #1;
         chk("R8 no strobe without request", 32'(wr_strobe_n), 32'd1);
      end
      ram_read(16'h0020, 8'h11, "R8 load without request");
      fire(16'h0020, 8'h77, 3'b000);
      ram_read(16'h0020, 8'h11, "R8 request without load");
      fire(16'h0020, 8'h66, 3'b010);
      ram_read(16'h0020, 8'h11, "R8 request with read code");
   endtask

   task automatic t_commit_timing;
      fire(16'h0030, 8'h22, 3'b011);
      @(negedge clk);
      addr = 16'h0030; bus_in = 8'h5A; ctrl_word = cw(3'b011, 1'b1);
      @(negedge clk);
      addr = 16'h0030; bus_in = 8'hFF; ctrl_word = cw(3'b010, 1'b0); #1;
      chk("R9 low at first sample", 32'(wr_strobe_n), 32'd0);
      chk("R9 old byte during strobe", 32'(bus_out), 32'h22);
      repeat (S - 1) @(negedge clk);
      #1;
      chk("R9 still low last cycle", 32'(wr_strobe_n), 32'd0);
      chk("R9 old byte last cycle", 32'(bus_out), 32'h22);
      @(negedge clk); #1;
      chk("R9 strobe released", 32'(wr_strobe_n), 32'd1);
      chk("R9 new byte after", 32'(bus_out), 32'h5A);
   endtask

   task automatic t_retrigger;
      int n;
      fire(16'h0041, 8'h0F, 3'b011);
      @(negedge clk);
      addr = 16'h0040; bus_in = 8'h33; ctrl_word = cw(3'b011, 1'b1);
      @(negedge clk);
      ctrl_word = 16'h0000; #1;
      n = 0;
      while (!wr_strobe_n && n < 4*S) begin
         n++;
         if (n == 2) begin
            addr = 16'h0041; bus_in = 8'h44; ctrl_word = cw(3'b011, 1'b1);
         end else begin
            ctrl_word = 16'h0000;
         end
         @(negedge clk); #1;
      end
      ctrl_word = 16'h0000;
      chk("R7 strobe not extended", 32'(n), 32'(S));
      ram_read(16'h0041, 8'h0F, "R7 ignored request wrote nothing");
      ram_read(16'h0040, 8'h33, "R7 first request written");
   endtask

   task automatic t_alias;
      rom_read(16'h8003);
      chk("R10 rom alias", 32'(bus_out), 32'(rom_exp(16'h0003)));
      fire(16'hFC10, 8'hB7, 3'b011);
      ram_read(16'h0010, 8'hB7, "R10 ram alias low");
      ram_read(16'h8410, 8'hB7, "R10 ram alias high");
   endtask

   task automatic t_exclusive;
      fire(16'h0001, 8'h00, 3'b011);
      rom_read(16'h0001);
      chk("R12 rom only", 32'(bus_out), 32'h25);
      ram_read(16'h0001, 8'h00, "R12 ram only");
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_rom();
      t_idle_codes();
      t_write_read();
      t_no_pulse_no_load();
      t_commit_timing();
      t_retrigger();
      t_alias();
      t_exclusive();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule